// File: doc/BRIEF.md
# Gated Continuous Pulse Train Generator

This block produces an endless square-wave-like pulse train whose low and high phase lengths are counted in clocks and can be changed while the train is running. Each period starts with its low phase and ends with its high phase. An active-high run gate controls the train. While the gate is high the phase counter advances. While it is low the train freezes in place, with the count and output level held, and it resumes exactly where it stopped.

A typical use feeds the gate from a single pulse whose width equals three periods of the train. Each gate then lets exactly three output pulses through, with the output left low afterwards. The timing specification is double-buffered. A write stores the new high and low counts in a staging register and drops `ready`. The staged values are copied into the active register at the next period boundary, which is the end of a high phase. `ready` returns only at the end of the first period that ran on the copied values. So a spec written as soon as `ready` rises governs the period after the next one. A write attempted while `ready` is low is discarded and sets a sticky error flag.

Top module: `pulse_train_gate`

## Requirements
- R1: While `rst_n` is low and after its release, `pulse_out` is 0, `ready` is 1 and `wr_err` is 0, and the active spec is `DEF_HI`/`DEF_LO`.
- R2: With `gate` held at 1, the output repeats periods of max(lo,1) clocks at 0 followed by max(hi,1) clocks at 1, indefinitely, starting from the low phase.
- R3: A clock edge with `gate` at 0 changes neither `pulse_out` nor the phase count, so no counts are lost across a pause.
- R4: From reset, holding `gate` at 1 for exactly three periods of clocks gives exactly three rising edges on `pulse_out` and leaves it at 0.
- R5: A write (`wr_en`=1 at an edge while `ready`=1) captures `wr_high`/`wr_low` and drives `ready` to 0 after that edge.
- R6: `ready` changes only on a write or a period boundary (a gated edge that ends a high phase). At a boundary with no staged spec waiting, `ready` returns to 1.
- R7: A staged spec becomes active at the first period boundary after the write, and the following period uses it.
- R8: A write while `ready`=0 changes no spec and sets `wr_err` to 1, which stays 1 until reset.
- R9: A high or low count of 0 is treated as 1 clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate | input | 1 | Run gate, 1 = advance, 0 = freeze |
| wr_en | input | 1 | Spec write strobe |
| wr_high | input | W | New high-phase length in clocks |
| wr_low | input | W | New low-phase length in clocks |
| pulse_out | output | 1 | Pulse train output |
| ready | output | 1 | 1 = a new spec may be written |
| wr_err | output | 1 | Sticky flag for a write rejected while not ready |

## Verification
The bench builds the block with W=8, DEF_HI=2 and DEF_LO=3, so one default period is five clocks and a three-pulse burst takes fifteen gated clocks. These short periods put several period boundaries, staged-spec handovers and ready cycles within a few dozen clocks. They also allow pauses to be placed inside either phase. Written specs of 0 and 1 reach the clamping case and the shortest possible two-clock period.

// File: rtl/pulse_train_gate.sv
module pulse_train_gate #(
  parameter int W      = 16,
  parameter int DEF_HI = 4,
  parameter int DEF_LO = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gate,
  input  logic         wr_en,
  input  logic [W-1:0] wr_high,
  input  logic [W-1:0] wr_low,
  output logic         pulse_out,
  output logic         ready,
  output logic         wr_err
);
  localparam logic [W-1:0] RST_HI = W'(DEF_HI);
  localparam logic [W-1:0] RST_LO = W'(DEF_LO);
  localparam logic [W-1:0] ONE    = W'(1);

  logic [W-1:0] act_hi, act_lo, stg_hi, stg_lo, cnt, len;
  logic         pend, hi_ph;

  wire [W-1:0] len_raw    = hi_ph ? act_hi : act_lo;
  assign       len        = (len_raw == '0) ? ONE : len_raw;
  wire         last       = (cnt == len - ONE);
  wire         period_end = gate && last && hi_ph;
  wire         take       = wr_en && ready;

  assign pulse_out = hi_ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_hi <= RST_HI;
      act_lo <= RST_LO;
      stg_hi <= RST_HI;
      stg_lo <= RST_LO;
      pend   <= 1'b0;
      cnt    <= '0;
      hi_ph  <= 1'b0;
      ready  <= 1'b1;
      wr_err <= 1'b0;
    end else begin
      if (gate) begin
        if (last) begin
          cnt   <= '0;
          hi_ph <= !hi_ph;
        end else begin
          cnt <= cnt + ONE;
        end
      end
      if (period_end && pend) begin
        act_hi <= stg_hi;
        act_lo <= stg_lo;
        pend   <= 1'b0;
      end
      if (take) begin
        stg_hi <= wr_high;
        stg_lo <= wr_low;
        pend   <= 1'b1;
        ready  <= 1'b0;
      end else if (period_end && !pend) begin
        ready  <= 1'b1;
      end
      if (wr_en && !ready) wr_err <= 1'b1;
    end
  end
endmodule

module pulse_train_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic gate,
  input logic wr_en,
  input logic pulse_out,
  input logic ready,
  input logic wr_err
);
  AST_PAUSE_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> $stable(pulse_out)); // R3
  AST_WRITE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ready) |=> !ready); // R5
  AST_READY_ONLY_AT_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && !wr_en) |=> $stable(ready)); // R6
  AST_BAD_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ready) |=> wr_err); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err); // R8
endmodule

bind pulse_train_gate pulse_train_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gate(gate), .wr_en(wr_en),
  .pulse_out(pulse_out), .ready(ready), .wr_err(wr_err)
);

// File: tb/pulse_train_gate_tb.sv
module pulse_train_gate_tb;
  localparam int W = 8, DH = 2, DL = 3;

  logic clk = 1'b0, rst_n = 1'b0, gate = 1'b0, wr_en = 1'b0;
  logic [W-1:0] wr_high = '0, wr_low = '0;
  logic pulse_out, ready, wr_err;

  int checks = 0, errors = 0, rises = 0;
  logic prev_out = 1'b0;
  bit   done = 1'b0;

  // behavioural reference state
  int m_hi = 0, m_left = DL, m_ahi = DH, m_alo = DL, m_shi = DH, m_slo = DL;
  int m_pend = 0, m_ready = 1, m_err = 0;

  always #10 clk = ~clk;

  pulse_train_gate #(.W(W), .DEF_HI(DH), .DEF_LO(DL)) u_dut (
    .clk(clk), .rst_n(rst_n), .gate(gate), .wr_en(wr_en),
    .wr_high(wr_high), .wr_low(wr_low),
    .pulse_out(pulse_out), .ready(ready), .wr_err(wr_err));

  function automatic int cl(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hi = 0; m_left = cl(DL); m_ahi = DH; m_alo = DL; m_shi = DH; m_slo = DL;
      m_pend = 0; m_ready = 1; m_err = 0;
    end else begin
      int o_ready, o_pend, bnd;
      o_ready = m_ready; o_pend = m_pend;
      bnd = (gate && m_hi == 1 && m_left == 1) ? 1 : 0;
      if (gate) begin
        if (m_left > 1) m_left = m_left - 1;
        else if (m_hi == 0) begin m_hi = 1; m_left = cl(m_ahi); end
        else begin
          if (m_pend != 0) begin m_ahi = m_shi; m_alo = m_slo; m_pend = 0; end
          m_hi = 0; m_left = cl(m_alo);
        end
      end
      if (wr_en && o_ready != 0) begin
        m_shi = int'(wr_high); m_slo = int'(wr_low); m_pend = 1; m_ready = 0;
      end else if (bnd != 0 && o_pend == 0) m_ready = 1;
      if (wr_en && o_ready == 0) m_err = 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("R2 pulse_out vs model", int'(pulse_out), m_hi);
    chk("R6 ready vs model", int'(ready), m_ready);
    chk("R8 wr_err vs model", int'(wr_err), m_err);
    if (pulse_out && !prev_out) rises++;
    prev_out = pulse_out;
  end

  task automatic run(input logic g, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #2;
      gate = g; wr_en = 1'b0;
    end
  endtask

  task automatic wr(input logic g, input int h, input int l);
    @(negedge clk); #2;
    gate = g; wr_en = 1'b1; wr_high = W'(h); wr_low = W'(l);
    @(negedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk); #2;
    rst_n = 1'b0; gate = 1'b0; wr_en = 1'b0;
    @(negedge clk); @(negedge clk); #2;
    rst_n = 1'b1;
  endtask

  initial begin
    int r0;
    do_reset();
    chk("R1 reset pulse_out", int'(pulse_out), 0);
    chk("R1 reset ready", int'(ready), 1);
    chk("R1 reset wr_err", int'(wr_err), 0);

    // R4: three default periods of gate give three pulses
    r0 = rises;
    run(1'b1, 3 * (DH + DL));
    run(1'b0, 1);
    chk("R4 burst rises", rises - r0, 3);
    chk("R4 burst ends low", int'(pulse_out), 0);
    run(1'b0, 6);
    chk("R4 no rise while paused", rises - r0, 3);

    // R3: pause inside high phase
    do_reset();
    run(1'b1, DL + 1);
    run(1'b0, 1);
    chk("R3 in high phase", int'(pulse_out), 1);
    run(1'b0, 5);
    chk("R3 held high", int'(pulse_out), 1);
    run(1'b1, 1);
    run(1'b0, 1);
    chk("R3 resumes remaining count", int'(pulse_out), 0);

    // R2: continuous run
    do_reset();
    r0 = rises;
    run(1'b1, 10 * (DH + DL));
    chk("R2 ten periods", rises - r0, 10);

    // R5/R7: write new spec, hi=1 lo=1
    wr(1'b1, 1, 1);
    chk("R5 ready dropped", int'(ready), 0);
    // R8: write while not ready
    wr(1'b1, 7, 7);
    chk("R8 err set", int'(wr_err), 1);
    run(1'b1, 40);
    chk("R8 err sticky", int'(wr_err), 1);
    chk("R6 ready back", int'(ready), 1);
    r0 = rises;
    run(1'b1, 20);
    chk("R7 new spec period 2", rises - r0, 10);

    // R9: zero counts clamp to one
    do_reset();
    wr(1'b1, 0, 0);
    run(1'b1, 30);
    r0 = rises;
    run(1'b1, 20);
    chk("R9 zero spec period 2", rises - r0, 10);

    // mixed pauses and writes, checked against the model each clock
    wr(1'b0, 3, 2);
    for (int k = 0; k < 60; k++) run(((k % 3) != 0) ? 1'b1 : 1'b0, 1);
    wr(1'b1, 2, 4);
    run(1'b1, 40);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule